// File: doc/BRIEF.md
# Dual-Channel Serial DAC Register Front-End

This block is the digital command decoder that sits in front of a two-channel voltage DAC. A host writes 16-bit command words over a three-wire link: an active-low select, a serial clock and a data line. The block oversamples all three lines in its own clock domain. It assembles each word MSB first and then decodes the word into updates of two 10-bit channel codes, a hidden holding buffer for channel B, and a small control register.

Every word carries a speed bit and a power-down bit. Two register-select bits, which sit at the two ends of the 4-bit header, pick one of four write actions. Channel B is double-buffered, so a host can stage a value for B and then load A and B in the same cycle. The serial link is a fixed-rate protocol without back-pressure: the block accepts every bit the host clocks in and never stalls the host. The outputs are plain levels that feed the analog section directly.

Top module: `dual_dac_frontend`

## Requirements
- R1: A falling edge of `cs_n` opens a frame. While `cs_n` is low, each falling edge of `sclk` shifts `din` in, MSB first. Clock edges while `cs_n` is high, and edges after the sixteenth bit of a frame, have no effect.
- R2: A frame commits when its sixteenth bit arrives or when `cs_n` rises, whichever happens first. A frame cut short is left-justified before decoding, with the missing low bits read as zero. A frame with no bits commits nothing.
- R3: Word layout: bit 15 is select-high, bit 14 is speed, bit 13 is power-down, bit 12 is select-low and bits 11..0 are the payload. Select 00 writes the payload code to both channel B and the holding buffer.
- R4: Select 01 writes the holding buffer only. `code_a` and `code_b` are left unchanged.
- R5: Select 10 writes the payload code to channel A and, in the same cycle, copies the previous holding-buffer value into channel B.
- R6: Select 11 writes `ref_sel` from payload bits 1..0 and leaves both codes unchanged. The encodings are 00 and 11 for external, 01 for the low internal level and 10 for the high internal level.
- R7: For a channel or buffer write, the code is payload bits 11..2. Payload bits 1..0 are ignored.
- R8: `fast_mode` takes bit 14 and `power_down` takes bit 13 of every committed word, whatever the select field holds.
- R9: Reset clears both codes, the holding buffer, `fast_mode`, `power_down` and `ref_sel` to zero. The outputs change only in the clock cycle after a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the serial link |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial bit clock; data is taken on its falling edge |
| din | input | 1 | Serial data, MSB first |
| code_a | output | 10 | Channel A code |
| code_b | output | 10 | Channel B code |
| fast_mode | output | 1 | 1 = fast settling, 0 = slow |
| power_down | output | 1 | 1 = analog section powered down |
| ref_sel | output | 2 | Reference selection code |

## Verification
The assertions assume that the serial lines change slowly compared with `clk`. Each level of `sclk`, and `din` around each falling edge, is assumed to be held for several block clocks, so that every edge is seen exactly once after synchronisation. They also assume that `cs_n` never rises in the same sampled cycle as an `sclk` falling edge. The stimulus holds each half period of `sclk` for four block clocks and changes `din` only while `sclk` is high. It waits four clocks after the last edge before it raises `cs_n`, and it leaves a quiet gap after each frame so that the commit settles before any check.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

  // Write action chosen by the split select field {bit15, bit12}.
  typedef enum logic [1:0] {
    DST_B_AND_HOLD = 2'b00,
    DST_HOLD_ONLY  = 2'b01,
    DST_A_XFER_B   = 2'b10,
    DST_CONTROL    = 2'b11
  } dst_e;

endpackage

// File: rtl/dacfe_insync.sv
module dacfe_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic din,
  output logic cs_lvl,
  output logic din_lvl,
  output logic sclk_fall,
  output logic cs_fall,
  output logic cs_rise
);
  // Each stage holds {din, sclk, cs_n}; the reset value is the idle line state.
  localparam logic [2:0] IDLE = 3'b011;

  logic [2:0] pipe [STAGES];
  logic [1:0] last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe[g] <= IDLE;
          else        pipe[g] <= {din, sclk, cs_n};
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe[g] <= IDLE;
          else        pipe[g] <= pipe[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 2'b11;
    else        last_q <= pipe[STAGES-1][1:0];

  assign cs_lvl    = pipe[STAGES-1][0];
  assign din_lvl   = pipe[STAGES-1][2];
  assign sclk_fall = last_q[1] & ~pipe[STAGES-1][1];
  assign cs_fall   = last_q[0] & ~pipe[STAGES-1][0];
  assign cs_rise   = ~last_q[0] & pipe[STAGES-1][0];

endmodule

// File: rtl/dacfe_shifter.sv
module dacfe_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_lvl,
  input  logic              din_lvl,
  input  logic              sclk_fall,
  input  logic              cs_fall,
  input  logic              cs_rise,
  output logic              word_valid,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              active;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] sh;
  logic [WORD_W-1:0] justified;
  logic [WORD_W-1:0] next_sh;

  assign justified = sh << (FULL - cnt);
  assign next_sh   = {sh[WORD_W-2:0], din_lvl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      cnt        <= '0;
      sh         <= '0;
      word_valid <= 1'b0;
      word       <= '0;
    end else begin
      word_valid <= 1'b0;
      if (cs_fall) begin
        active <= 1'b1;
        cnt    <= '0;
        sh     <= '0;
      end else if (active && cs_rise) begin
        active <= 1'b0;
        if (cnt != '0) begin
          word_valid <= 1'b1;
          word       <= justified;
        end
      end else if (active && sclk_fall && !cs_lvl) begin
        sh  <= next_sh;
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          active     <= 1'b0;
          word_valid <= 1'b1;
          word       <= next_sh;
        end
      end
    end
  end

  assert_bit_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

  assert_idle_ignores_edges_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !cs_fall) |=> $stable(sh));

  assert_commit_closes_open_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(active));

endmodule

// File: rtl/dacfe_regs.sv
module dacfe_regs
  import dacfe_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              fast_mode,
  output logic              power_down,
  output logic [1:0]        ref_sel
);
  localparam int PAY_W  = WORD_W - 4;
  localparam int SEL_HI = WORD_W - 1;
  localparam int SPD_B  = WORD_W - 2;
  localparam int PD_B   = WORD_W - 3;
  localparam int SEL_LO = WORD_W - 4;

  logic [PAY_W-1:0]  payload;
  logic [CODE_W-1:0] new_code;
  logic [CODE_W-1:0] hold_q;
  dst_e              dst;

  assign payload  = word[PAY_W-1:0];
  assign new_code = payload[PAY_W-1 -: CODE_W];
  assign dst      = dst_e'({word[SEL_HI], word[SEL_LO]});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_a     <= '0;
      code_b     <= '0;
      hold_q     <= '0;
      fast_mode  <= 1'b0;
      power_down <= 1'b0;
      ref_sel    <= 2'b00;
    end else if (word_valid) begin
      fast_mode  <= word[SPD_B];
      power_down <= word[PD_B];
      case (dst)
        DST_B_AND_HOLD: begin
          code_b <= new_code;
          hold_q <= new_code;
        end
        DST_HOLD_ONLY: hold_q <= new_code;
        DST_A_XFER_B: begin
          code_a <= new_code;
          code_b <= hold_q;
        end
        default: ref_sel <= payload[1:0];
      endcase
    end
  end

  assert_hold_write_keeps_codes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && dst == DST_HOLD_ONLY) |=> ($stable(code_a) && $stable(code_b)));

  assert_b_takes_old_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && dst == DST_A_XFER_B) |=> (code_b == $past(hold_q)));

  assert_control_keeps_codes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && dst == DST_CONTROL) |=> ($stable(code_a) && $stable(code_b)));

  assert_flags_follow_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> (fast_mode == $past(word[SPD_B]) && power_down == $past(word[PD_B])));

  assert_outputs_quiet_without_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |=> ($stable(code_a) && $stable(code_b) && $stable(ref_sel)
                     && $stable(fast_mode) && $stable(power_down)));

endmodule

// File: rtl/dual_dac_frontend.sv
module dual_dac_frontend #(
  parameter int WORD_W      = 16,
  parameter int CODE_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              fast_mode,
  output logic              power_down,
  output logic [1:0]        ref_sel
);
  logic cs_lvl, din_lvl, sclk_fall, cs_fall, cs_rise;
  logic              word_valid;
  logic [WORD_W-1:0] word;

  dacfe_insync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .din       (din),
    .cs_lvl    (cs_lvl),
    .din_lvl   (din_lvl),
    .sclk_fall (sclk_fall),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise)
  );

  dacfe_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_lvl     (cs_lvl),
    .din_lvl    (din_lvl),
    .sclk_fall  (sclk_fall),
    .cs_fall    (cs_fall),
    .cs_rise    (cs_rise),
    .word_valid (word_valid),
    .word       (word)
  );

  dacfe_regs #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_valid (word_valid),
    .word       (word),
    .code_a     (code_a),
    .code_b     (code_b),
    .fast_mode  (fast_mode),
    .power_down (power_down),
    .ref_sel    (ref_sel)
  );

endmodule

// File: tb/dual_dac_frontend_tb.sv
module dual_dac_frontend_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b1;
  logic din = 1'b0;
  logic [9:0] code_a, code_b;
  logic fast_mode, power_down;
  logic [1:0] ref_sel;

  int n_checks = 0;
  int n_fail = 0;
  logic [9:0] ea = '0, eb = '0;
  logic ef = 1'b0, ep = 1'b0;
  logic [1:0] er = 2'b00;

  always #4 clk = ~clk;

  dual_dac_frontend u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .code_a(code_a), .code_b(code_b), .fast_mode(fast_mode),
    .power_down(power_down), .ref_sel(ref_sel)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " code_a"}, int'(code_a), int'(ea));
    check({tag, " code_b"}, int'(code_b), int'(eb));
    check({tag, " fast_mode"}, int'(fast_mode), int'(ef));
    check({tag, " power_down"}, int'(power_down), int'(ep));
    check({tag, " ref_sel"}, int'(ref_sel), int'(er));
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] mk(input logic r1, input logic spd, input logic pd,
                                     input logic r0, input logic [11:0] pay);
    return {r1, spd, pd, r0, pay};
  endfunction

  // Clocks nbits bits of w (bits beyond the sixteenth are driven as ones).
  task automatic send(input logic [15:0] w, input int nbits);
    cs_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      din = (i < 16) ? w[15-i] : 1'b1;
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
      wait_clk(4);
      sclk = 1'b1;
    end
    wait_clk(4);
    cs_n = 1'b1;
    wait_clk(12);
  endtask

  task automatic t_reset;
    check_all("R9 reset");
  endtask

  task automatic t_write_b;
    send(mk(0, 0, 0, 0, {10'h2A5, 2'b11}), 16);
    eb = 10'h2A5;
    check_all("R3 R7 select00");
  endtask

  task automatic t_hold_only;
    send(mk(0, 1, 0, 1, {10'h0F3, 2'b10}), 16);
    ef = 1'b1;
    check_all("R4 select01");
  endtask

  task automatic t_xfer;
    send(mk(1, 1, 0, 0, {10'h155, 2'b01}), 16);
    ea = 10'h155; eb = 10'h0F3;
    check_all("R5 select10");
  endtask

  task automatic t_control;
    send(mk(1, 0, 1, 1, {10'h3FF, 2'b10}), 16);
    ef = 1'b0; ep = 1'b1; er = 2'b10;
    check_all("R6 control high");
    send(mk(1, 0, 0, 1, {10'h000, 2'b01}), 16);
    ep = 1'b0; er = 2'b01;
    check_all("R6 control low");
  endtask

  task automatic t_short_frame;
    // 12 bits of 0x0FFF arrive, justified to 0x0FF0: select 00, code 0x3FC.
    send(16'h0FFF, 12);
    eb = 10'h3FC;
    check_all("R2 short frame");
  endtask

  task automatic t_idle_edges;
    cs_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      din = 1'b1;
      sclk = 1'b0; wait_clk(4);
      sclk = 1'b1; wait_clk(4);
    end
    wait_clk(8);
    check_all("R1 edges with cs high");
  endtask

  task automatic t_overlong;
    send(mk(1, 1, 1, 0, {10'h001, 2'b00}), 20);
    ea = 10'h001; eb = 10'h3FC; ef = 1'b1; ep = 1'b1;
    check_all("R1 R2 extra edges");
  endtask

  task automatic t_empty_frame;
    cs_n = 1'b0; wait_clk(8);
    cs_n = 1'b1; wait_clk(12);
    check_all("R2 empty frame");
  endtask

  task automatic t_flags_any;
    send(mk(0, 1, 0, 1, {10'h200, 2'b11}), 16);
    ef = 1'b1; ep = 1'b0;
    check_all("R8 flags on hold write");
    send(mk(1, 0, 1, 0, {10'h011, 2'b00}), 16);
    ea = 10'h011; eb = 10'h200; ef = 1'b0; ep = 1'b1;
    check_all("R8 R5 flags on transfer");
  endtask

  task automatic t_reset_midway;
    wait_clk(2);
    rst_n = 1'b0; wait_clk(3);
    rst_n = 1'b1; wait_clk(4);
    ea = '0; eb = '0; ef = 1'b0; ep = 1'b0; er = 2'b00;
    check_all("R9 reset again");
    // the holding buffer must also be cleared
    send(mk(1, 0, 0, 0, {10'h0AA, 2'b00}), 16);
    ea = 10'h0AA; eb = 10'h000;
    check_all("R9 hold cleared");
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_write_b();
    t_hold_only();
    t_xfer();
    t_control();
    t_short_frame();
    t_idle_edges();
    t_overlong();
    t_empty_frame();
    t_flags_any();
    t_reset_midway();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule